// File: doc/BRIEF.md
# Block Translation Lookup

This block translates an effective address through a small set of block-translation entries, with one set for instruction fetches and one for data accesses. Each entry has an upper word and a lower word. The upper word holds the effective block base, a length code and two valid bits, one for supervisor mode and one for user mode. The lower word holds the physical block base and a two-bit protection code. A block covers from 128 KiB up to 256 MiB. Setting more length bits removes more base bits from the comparison.

A request gives an effective address, a privilege flag and an access kind. One cycle later the block reports hit or miss, the physical page address and a read/write/execute permission vector. The first matching entry in index order wins. Software or a sequencer loads the entries through a write port that addresses one word at a time. Page-table walking and fault generation happen elsewhere.

Top module: `blk_xlate_match`

## Requirements
- R1: After reset every entry word is zero and all response outputs are zero, so any lookup misses.
- R2: A request with `req_kind` = 2 (instruction fetch) searches the instruction set. Kinds 0 (read), 1 (write) and 3 search the data set.
- R3: An entry is usable only when upper-word bit 1 is set for a supervisor request (`req_priv`=1), or when upper-word bit 0 is set for a user request (`req_priv`=0). An unusable entry never hits.
- R4: The match mask of a usable entry is the base field mask (bits 31:17) with bits cleared where the length field (upper bits 12:2), shifted left by 15, has ones.
- R5: An entry hits when the effective address ANDed with its mask equals the upper word's bits 31:17, with all other bits taken as zero.
- R6: On a hit the reported address is (lower word AND mask) OR (effective address AND NOT mask), with bits 11:0 forced to zero.
- R7: `rsp_perm` holds read in bit 0, write in bit 1 and execute in bit 2. It is decoded from lower-word bits 1:0 as follows: code 0 gives 000, code 2 gives 111, and codes 1 and 3 give 101. A hit with code 0 still reports a hit.
- R8: When several entries hit, the entry with the lowest index supplies the result.
- R9: A lookup with no hit reports `rsp_hit`=0, `rsp_pa`=0 and `rsp_perm`=0.
- R10: `rsp_valid` is `req_valid` delayed by one cycle. The result outputs change only on the cycle after an accepted request and hold their value otherwise.
- R11: A write with `wr_en`=1 stores `wr_data` into entry `wr_idx`. It goes to the instruction set when `wr_instr`=1 and to the data set otherwise, and to the lower word when `wr_lower`=1 and to the upper word otherwise. Lookups see the new value from the next cycle on, and the other set is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Entry word write strobe |
| wr_instr | input | 1 | 1 selects the instruction set for the write |
| wr_lower | input | 1 | 1 writes the lower word, 0 the upper word |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_priv | input | 1 | 1 supervisor, 0 user |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | An entry matched |
| rsp_pa | output | 32 | Translated page address |
| rsp_perm | output | 3 | {execute, write, read} |

## Verification
The hardest case to reach from the ports is several usable entries covering the same address with different block lengths. In that case the lowest index must win, even when a later entry has the wider block. The fixed table loads a 128 KiB supervisor-only entry and a 2 MiB entry usable in both modes over the same base. It then probes addresses inside the small block, outside the small block but inside the large one, and the same address in user mode. A randomized phase aims most addresses at a chosen entry's block, so that hits and overlaps occur often, and compares the results with a model built from the requirements.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;
   typedef struct packed {
      word_t upper;
      word_t lower;
   } pair_t;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;
endpackage

// File: rtl/blk_xlate_regs.sv
module blk_xlate_regs
   import blk_xlate_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int IDX_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_instr,
   input  logic             wr_lower,
   input  logic [IDX_W-1:0] wr_idx,
   input  word_t            wr_data,
   input  logic             use_instr,
   output pair_t            sel_pairs [NUM_ENTRIES]
);
   // bank 0 holds data entries, bank 1 instruction entries
   for (genvar b = 0; b < 2; b++) begin : g_bank
      pair_t q [NUM_ENTRIES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int e = 0; e < NUM_ENTRIES; e++) q[e] <= '0;
         end else if (wr_en && (wr_instr == 1'(b)) && (int'(wr_idx) < NUM_ENTRIES)) begin
            if (wr_lower) q[wr_idx].lower <= wr_data;
            else          q[wr_idx].upper <= wr_data;
         end
      end
   end

   always_comb begin
      for (int e = 0; e < NUM_ENTRIES; e++)
         sel_pairs[e] = use_instr ? g_bank[1].q[e] : g_bank[0].q[e];
   end
endmodule

// File: rtl/blk_xlate_entry.sv
module blk_xlate_entry
   import blk_xlate_pkg::*;
#(
   parameter int EBI_LSB   = 17,
   parameter int LEN_LSB   = 2,
   parameter int LEN_W     = 11,
   parameter int PAGE_BITS = 12,
   parameter int SV_BIT    = 1,
   parameter int UV_BIT    = 0
) (
   input  pair_t      pair,
   input  word_t      ea,
   input  logic       priv,
   output logic       hit,
   output word_t      pa,
   output logic [2:0] perm
);
   localparam word_t EBI_MASK  = ~word_t'((64'd1 << EBI_LSB) - 64'd1);
   localparam word_t LEN_FMASK = word_t'(((64'd1 << LEN_W) - 64'd1) << LEN_LSB);
   localparam int    LEN_SHIFT = EBI_LSB - LEN_LSB;
   localparam word_t PAGE_MASK = ~word_t'((64'd1 << PAGE_BITS) - 64'd1);

   logic  usable;
   word_t mask;

   always_comb begin
      usable = priv ? pair.upper[SV_BIT] : pair.upper[UV_BIT];
      mask   = usable ? (EBI_MASK & ~((pair.upper & LEN_FMASK) << LEN_SHIFT)) : '0;
      hit    = usable && ((ea & mask) == (pair.upper & EBI_MASK));
      pa     = ((pair.lower & mask) | (ea & ~mask)) & PAGE_MASK;
      unique case (pair.lower[1:0])
         2'd0:    perm = 3'b000;
         2'd2:    perm = 3'b111;
         default: perm = 3'b101;
      endcase
   end
endmodule

// File: rtl/blk_xlate_pick.sv
module blk_xlate_pick
   import blk_xlate_pkg::*;
#(
   parameter int NUM_ENTRIES = 4
) (
   input  logic [NUM_ENTRIES-1:0] hit_vec,
   input  word_t                  pa_in   [NUM_ENTRIES],
   input  logic [2:0]             perm_in [NUM_ENTRIES],
   output logic                   any_hit,
   output word_t                  pa,
   output logic [2:0]             perm
);
   // scanned from the top down so the lowest index overrides
   always_comb begin
      any_hit = 1'b0;
      pa      = '0;
      perm    = '0;
      for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
         if (hit_vec[e]) begin
            any_hit = 1'b1;
            pa      = pa_in[e];
            perm    = perm_in[e];
         end
      end
   end
endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
   import blk_xlate_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int EBI_LSB     = 17,
   parameter int LEN_LSB     = 2,
   parameter int LEN_W       = 11,
   parameter int PAGE_BITS   = 12,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_instr,
   input  logic             wr_lower,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wr_data,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic             req_priv,
   input  logic [31:0]      req_ea,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [31:0]      rsp_pa,
   output logic [2:0]       rsp_perm
);
   if (NUM_ENTRIES < 2)
      $error("NUM_ENTRIES must be at least 2");
   if (LEN_LSB < 2)
      $error("length field overlaps the valid bits");
   if (LEN_LSB + LEN_W > EBI_LSB)
      $error("length field overlaps the base field");
   if (EBI_LSB + LEN_W > WORD_W)
      $error("shifted length field exceeds the word");
   if (PAGE_BITS > EBI_LSB)
      $error("page offset wider than smallest block");

   logic                   use_instr;
   pair_t                  pairs   [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] hit_vec;
   word_t                  pa_vec  [NUM_ENTRIES];
   logic [2:0]             perm_vec[NUM_ENTRIES];
   logic                   any_hit;
   word_t                  pick_pa;
   logic [2:0]             pick_perm;

   assign use_instr = (acc_e'(req_kind) == ACC_FETCH);

   blk_xlate_regs #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instr(wr_instr),
      .wr_lower(wr_lower), .wr_idx(wr_idx), .wr_data(wr_data),
      .use_instr(use_instr), .sel_pairs(pairs)
   );

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      blk_xlate_entry #(
         .EBI_LSB(EBI_LSB), .LEN_LSB(LEN_LSB), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)
      ) u_ent (
         .pair(pairs[e]), .ea(req_ea), .priv(req_priv),
         .hit(hit_vec[e]), .pa(pa_vec[e]), .perm(perm_vec[e])
      );
   end

   blk_xlate_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
      .hit_vec(hit_vec), .pa_in(pa_vec), .perm_in(perm_vec),
      .any_hit(any_hit), .pa(pick_pa), .perm(pick_perm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pa    <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit  <= any_hit;
            rsp_pa   <= pick_pa;
            rsp_perm <= pick_perm;
         end
      end
   end
endmodule

// File: rtl/blk_xlate_match_chk.sv
module blk_xlate_match_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        rsp_valid,
   input logic        rsp_hit,
   input logic [31:0] rsp_pa,
   input logic [2:0]  rsp_perm
);
   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_hit) && $stable(rsp_pa) && $stable(rsp_perm)));
   assert_page_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pa[11:0] == 12'h000);
   assert_miss_is_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_pa == 32'h0 && rsp_perm == 3'b000));
   assert_perm_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_perm[0] == rsp_perm[2]) && (!rsp_perm[1] || rsp_perm[0]));
endmodule

bind blk_xlate_match blk_xlate_match_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
   .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm)
);

// File: tb/blk_xlate_match_test.sv
`timescale 1ns/1ps
module blk_xlate_match_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_instr = 1'b0, wr_lower = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0, req_priv = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [31:0] req_ea = '0;
   logic        rsp_valid, rsp_hit;
   logic [31:0] rsp_pa;
   logic [2:0]  rsp_perm;
   int          n_vec = 0, n_bad = 0;
   logic [31:0] mu [2][4];
   logic [31:0] ml [2][4];

   always #5 clk = ~clk;

   blk_xlate_match uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instr(wr_instr),
      .wr_lower(wr_lower), .wr_idx(wr_idx), .wr_data(wr_data),
      .req_valid(req_valid), .req_kind(req_kind), .req_priv(req_priv),
      .req_ea(req_ea), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_pa(rsp_pa), .rsp_perm(rsp_perm)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic        priv;
      logic [31:0] ea;
      logic        hit;
      logic [31:0] pa;
      logic [2:0]  perm;
   } vec_t;

   // expected values worked out from R2..R9 for the entries loaded below
   localparam vec_t VECS [11] = '{
      '{2'd0, 1'b1, 32'h1000_1234, 1'b1, 32'h8000_1000, 3'b111}, // R3 R7 sup entry 0
      '{2'd1, 1'b0, 32'h1000_1234, 1'b1, 32'hC000_1000, 3'b101}, // R3 R8 user skips 0
      '{2'd0, 1'b1, 32'h101F_F800, 1'b1, 32'hC01F_F000, 3'b101}, // R4 R8 wide entry
      '{2'd0, 1'b0, 32'h2ABC_DEF0, 1'b1, 32'h4ABC_D000, 3'b101}, // R4 R6 256 MiB block
      '{2'd0, 1'b1, 32'h2ABC_DEF0, 1'b0, 32'h0000_0000, 3'b000}, // R3 R9 user-only
      '{2'd1, 1'b1, 32'h3000_0ABC, 1'b1, 32'h5000_0000, 3'b000}, // R7 code 0
      '{2'd2, 1'b1, 32'h1000_1234, 1'b1, 32'h6000_1000, 3'b101}, // R2 fetch set
      '{2'd2, 1'b0, 32'h2ABC_DEF0, 1'b0, 32'h0000_0000, 3'b000}, // R2 R9
      '{2'd0, 1'b1, 32'h4000_0000, 1'b0, 32'h0000_0000, 3'b000}, // R9
      '{2'd2, 1'b0, 32'h1001_FFFF, 1'b1, 32'h6001_F000, 3'b101}, // R5 block top
      '{2'd0, 1'b1, 32'h1002_0000, 1'b1, 32'hC002_0000, 3'b101}  // R5 R8 boundary
   };

   task automatic wr(input logic instr, input int idx, input logic lower, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_instr = instr; wr_idx = 2'(idx); wr_lower = lower; wr_data = d;
      if (lower) ml[instr][idx] = d; else mu[instr][idx] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic look(input logic [1:0] kind, input logic priv, input logic [31:0] ea);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_priv = priv; req_ea = ea;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic check(input string tag, input logic v, input logic h,
                        input logic [31:0] pa, input logic [2:0] pm);
      n_vec++;
      if (rsp_valid !== v || rsp_hit !== h || rsp_pa !== pa || rsp_perm !== pm) begin
         n_bad++;
         $display("FAIL %s: got v=%b hit=%b pa=%h perm=%b, expected v=%b hit=%b pa=%h perm=%b",
                  tag, rsp_valid, rsp_hit, rsp_pa, rsp_perm, v, h, pa, pm);
      end
   endtask

   function automatic void model(input logic [1:0] kind, input logic priv, input logic [31:0] ea,
                                 output logic hit, output logic [31:0] pa, output logic [2:0] pm);
      int a = (kind == 2'd2) ? 1 : 0;
      hit = 1'b0; pa = '0; pm = '0;
      for (int e = 0; e < 4; e++) begin
         logic [31:0] u = mu[a][e];
         logic [31:0] m;
         logic ok = priv ? u[1] : u[0];
         m = ok ? (32'hFFFE_0000 & ~((u & 32'h0000_1FFC) << 15)) : 32'h0;
         if (!hit && ok && ((ea & m) == (u & 32'hFFFE_0000))) begin
            hit = 1'b1;
            pa  = ((ml[a][e] & m) | (ea & ~m)) & 32'hFFFF_F000;
            pm  = (ml[a][e][1:0] == 2'd0) ? 3'b000 : (ml[a][e][1:0] == 2'd2) ? 3'b111 : 3'b101;
         end
      end
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < 2; a++) for (int e = 0; e < 4; e++) begin mu[a][e] = '0; ml[a][e] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset outputs", 1'b0, 1'b0, 32'h0, 3'b000);
      look(2'd0, 1'b1, 32'h0000_0000);
      check("R1 cleared data set", 1'b1, 1'b0, 32'h0, 3'b000);
      look(2'd2, 1'b0, 32'h0000_0000);
      check("R1 cleared instr set", 1'b1, 1'b0, 32'h0, 3'b000);

      // R11 load entries one word at a time
      wr(1'b0, 0, 1'b0, 32'h1000_0002); wr(1'b0, 0, 1'b1, 32'h8000_0002);
      wr(1'b0, 1, 1'b0, 32'h2000_1FFD); wr(1'b0, 1, 1'b1, 32'h4000_0001);
      wr(1'b0, 2, 1'b0, 32'h1000_003F); wr(1'b0, 2, 1'b1, 32'hC000_0003);
      wr(1'b0, 3, 1'b0, 32'h3000_0003); wr(1'b0, 3, 1'b1, 32'h5000_0000);
      wr(1'b1, 0, 1'b0, 32'h1000_0003); wr(1'b1, 0, 1'b1, 32'h6000_0001);

      for (int i = 0; i < 11; i++) begin
         look(VECS[i].kind, VECS[i].priv, VECS[i].ea);
         check($sformatf("table %0d R2 R3 R4 R5 R6 R7 R8 R9", i), 1'b1,
               VECS[i].hit, VECS[i].pa, VECS[i].perm);
      end

      // R10 outputs hold while no request is presented
      look(2'd0, 1'b1, 32'h1000_1234);
      @(negedge clk);
      req_ea = 32'h2ABC_DEF0; req_priv = 1'b0;
      @(negedge clk);
      check("R10 hold without request", 1'b0, 1'b1, 32'h8000_1000, 3'b111);

      // R11 rewrite of one word is seen next cycle, other set untouched
      wr(1'b0, 0, 1'b1, 32'h9000_0000);
      look(2'd0, 1'b1, 32'h1000_1234);
      check("R11 lower rewrite R7 code 0", 1'b1, 1'b1, 32'h9000_1000, 3'b000);
      look(2'd2, 1'b1, 32'h1000_1234);
      check("R11 instr set unchanged", 1'b1, 1'b1, 32'h6000_1000, 3'b101);

      // random contents against the model (R4 R5 R6 R7 R8)
      for (int r = 0; r < 20; r++) begin
         for (int a = 0; a < 2; a++) for (int e = 0; e < 4; e++) begin
            logic [31:0] len = 32'($urandom_range(0, 2047));
            wr(1'(a), e, 1'b0, ($urandom & 32'hFFFE_0000 & ~(len << 17)) | (len << 2)
                              | 32'($urandom_range(0, 3)));
            wr(1'(a), e, 1'b1, $urandom);
         end
         for (int k = 0; k < 25; k++) begin
            logic [1:0]  kind = 2'($urandom_range(0, 3));
            logic        priv = 1'($urandom_range(0, 1));
            logic [31:0] u = mu[(kind == 2'd2) ? 1 : 0][$urandom_range(0, 3)];
            logic [31:0] ea;
            logic        eh;
            logic [31:0] ep;
            logic [2:0]  em;
            ea = ($urandom_range(0, 4) == 0) ? $urandom
                 : ((u & 32'hFFFE_0000) | ($urandom & 32'h0001_FFFF)
                    | ($urandom & ((u & 32'h0000_1FFC) << 15)));
            model(kind, priv, ea, eh, ep, em);
            look(kind, priv, ea);
            check($sformatf("random ea=%h R4 R5 R6 R7 R8", ea), 1'b1, eh, ep, em);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule